// File: doc/BRIEF.md
# Exception Cause and Status Unit

This block records exceptions for the system control coprocessor of a 32-bit processor core. It holds three architectural registers: the processor status word, the exception cause word and the exception return address. The pipeline presents, every cycle, the PC of the instruction at the head of the pipe, a flag saying whether it sits in a branch-delay slot and, for a coprocessor fault, the coprocessor number. When it raises a synchronous exception it also presents a 5-bit code. Eight interrupt request lines are sampled every cycle into the cause word. The unit decides whether an interrupt is taken and reports the accepted exception and its code in the same cycle. The architectural registers change at the next clock edge.

Software reaches the three registers through one write port and one read port, each with a 2-bit register select. A return-from-exception strobe leaves the current exception or error level, and the saved return address is always driven out as the return target. A soft-reset or non-maskable event input raises the error level. Address translation, vector address generation and the pipeline itself live outside the block.

Top module: `trap_status_unit`

## Requirements
- R1: After reset the status word reads 0x0040_0004 (error level and boot-vector bit set), and the cause word and the return address read zero.
- R2: A synchronous request (`exc_req`=1, `err_evt`=0) is accepted in the same cycle: `trap_taken`=1 and `trap_code`=`exc_code`. After the next edge, cause bits 6:2 hold that code and status bit 1 (exception level) is 1.
- R3: When an exception is accepted with `cur_in_slot`=1, the return address becomes `cur_pc`-4 and cause bit 31 becomes 1. With `cur_in_slot`=0 it becomes `cur_pc` and cause bit 31 becomes 0.
- R4: An accepted exception with code 11 (coprocessor unusable) stores `cur_cop` in cause bits 29:28. Any other accepted code clears those bits.
- R5: Cause bits 15:8 show the value of `irq_lines` from the previous cycle, one bit per line. Software writes do not change them.
- R6: With no synchronous request, an interrupt is taken only when status bit 0 (enable) is 1, status bits 1 and 2 are 0, and (cause bits 15:8 AND status bits 15:8) is nonzero. It is reported with code 0 and records the return address and the slot flag as in R3.
- R7: If a synchronous request and a takeable interrupt meet in one cycle, the synchronous code is reported. Only one exception is accepted per cycle.
- R8: A return strobe with no exception in the same cycle clears status bit 2 if it is set, and otherwise clears status bit 1. `ret_target` always equals the saved return address.
- R9: `err_evt` sets status bit 2. It blocks exception acceptance, the return strobe and the software write in the same cycle.
- R10: Register select codes are 0 for status, 1 for cause, 2 for return address and 3 for none (reads zero, write ignored). A software write is applied only in a cycle with no exception, return or `err_evt`.
- R11: Status keeps only enable (bit 0), exception level (1), error level (2), privilege mode (4:3), interrupt mask (15:8), boot vector (22) and coprocessor usable (31:28). A software write to cause changes only bits 6:2, 29:28 and 31. All other bits of both words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 1 | Soft reset or non-maskable event; raises the error level |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code of the synchronous exception |
| cur_pc | input | 32 | PC of the instruction at the head of the pipe |
| cur_in_slot | input | 1 | That instruction sits in a branch-delay slot |
| cur_cop | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| irq_lines | input | NUM_IRQ | Interrupt request lines |
| eret | input | 1 | Return-from-exception strobe |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Software write register select |
| sw_wdata | input | 32 | Software write data |
| rd_sel | input | 2 | Software read register select |
| trap_taken | output | 1 | An exception is accepted this cycle |
| trap_code | output | 5 | Code of the accepted exception |
| ret_target | output | 32 | Saved return address |
| rd_data | output | 32 | Software read data |
| status_out | output | 32 | Current status word |

## Verification
The bound checker watches several rules on every cycle. The exception level must rise after any accepted exception, and the recorded code must match. A synchronous request must win over an interrupt. No interrupt may be taken while enable is off or either level is set. The return address and slot flag must be recorded correctly, and `err_evt` must block and raise the error level. Reserved bits must stay zero. Only the bench's scenarios can show some behaviours: the exact reset values, the one-cycle lag of the pending bits, software writes being dropped when they collide with hardware events, and the order in which a return clears the error level before the exception level.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  localparam int XLEN = 32;

  // status word field positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_IM  = 8;

  // cause word field positions
  localparam int CA_CODE = 2;
  localparam int CA_IP   = 8;
  localparam int CA_CE   = 28;
  localparam int CA_BD   = 31;

  localparam logic [XLEN-1:0] STAT_KEEP  = 32'hF040_FF1F;
  localparam logic [XLEN-1:0] STAT_RESET = 32'h0040_0004;
  localparam logic [XLEN-1:0] CAUSE_SWMASK = 32'hB000_007C;
  localparam logic [XLEN-1:0] CAUSE_LIVE   = 32'hB000_FF7C;

  localparam logic [4:0] CODE_IRQ    = 5'd0;
  localparam logic [4:0] CODE_COPUNU = 5'd11;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_RETPC  = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_e;
endpackage

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter #(
  parameter int NUM_IRQ = 8
) (
  input  logic               st_ie,
  input  logic               st_exl,
  input  logic               st_erl,
  input  logic [NUM_IRQ-1:0] st_im,
  input  logic [NUM_IRQ-1:0] ip_q,
  input  logic               err_evt,
  input  logic               exc_req,
  input  logic [4:0]         exc_code,
  input  logic               eret,
  input  logic               sw_we,
  output logic               trap_take,
  output logic [4:0]         trap_code,
  output logic               do_erl,
  output logic               do_ret,
  output logic               do_wr
);
  import trap_pkg::*;

  logic [NUM_IRQ-1:0] pend;
  logic               irq_ok;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
    assign pend[gi] = ip_q[gi] & st_im[gi];
  end

  always_comb begin
    irq_ok    = st_ie & ~st_exl & ~st_erl & (|pend);
    do_erl    = err_evt;
    trap_take = ~err_evt & (exc_req | irq_ok);
    trap_code = exc_req ? exc_code : CODE_IRQ;
    do_ret    = ~err_evt & ~trap_take & eret;
    do_wr     = ~err_evt & ~trap_take & ~eret & sw_we;
  end
endmodule

// File: rtl/trap_status_reg.sv
`timescale 1ns/1ps
module trap_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        do_erl,
  input  logic        do_trap,
  input  logic        do_ret,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] status_q
);
  import trap_pkg::*;

  logic [31:0] st_d;
  logic        st_en;

  always_comb begin
    st_d  = status_q;
    st_en = do_erl | do_trap | do_ret | wr_en;
    if (do_erl) begin
      st_d[ST_ERL] = 1'b1;
    end else if (do_trap) begin
      st_d[ST_EXL] = 1'b1;
    end else if (do_ret) begin
      if (status_q[ST_ERL]) st_d[ST_ERL] = 1'b0;
      else                  st_d[ST_EXL] = 1'b0;
    end else if (wr_en) begin
      st_d = wdata & STAT_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= STAT_RESET;
    else if (st_en) status_q <= st_d;
  end
endmodule

// File: rtl/trap_record.sv
`timescale 1ns/1ps
module trap_record #(
  parameter int NUM_IRQ    = 8,
  parameter int SLOT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               do_trap,
  input  logic [4:0]         trap_code,
  input  logic [31:0]        cur_pc,
  input  logic               cur_in_slot,
  input  logic [1:0]         cur_cop,
  input  logic               wr_cause,
  input  logic               wr_epc,
  input  logic [31:0]        wdata,
  output logic [NUM_IRQ-1:0] ip_q,
  output logic [31:0]        cause_q,
  output logic [31:0]        epc_q
);
  import trap_pkg::*;

  localparam logic [31:0] SLOT_STEP = 32'(SLOT_BYTES);

  logic [4:0]  code_q, code_d;
  logic        bd_q, bd_d;
  logic [1:0]  ce_q, ce_d;
  logic [31:0] epc_d;
  logic        rec_en, epc_en;

  always_comb begin
    code_d = code_q;
    bd_d   = bd_q;
    ce_d   = ce_q;
    epc_d  = epc_q;
    rec_en = do_trap | wr_cause;
    epc_en = do_trap | wr_epc;
    if (do_trap) begin
      code_d = trap_code;
      bd_d   = cur_in_slot;
      ce_d   = (trap_code == CODE_COPUNU) ? cur_cop : 2'b00;
      epc_d  = cur_in_slot ? (cur_pc - SLOT_STEP) : cur_pc;
    end else begin
      if (wr_cause) begin
        code_d = wdata[CA_CODE +: 5];
        bd_d   = wdata[CA_BD];
        ce_d   = wdata[CA_CE +: 2];
      end
      if (wr_epc) epc_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= irq_lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      bd_q   <= 1'b0;
      ce_q   <= '0;
    end else if (rec_en) begin
      code_q <= code_d;
      bd_q   <= bd_d;
      ce_q   <= ce_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_comb begin
    cause_q = '0;
    cause_q[CA_BD]        = bd_q;
    cause_q[CA_CE +: 2]   = ce_q;
    cause_q[CA_CODE +: 5] = code_q;
    for (int i = 0; i < NUM_IRQ; i++) cause_q[CA_IP + i] = ip_q[i];
  end
endmodule

// File: rtl/trap_status_unit.sv
`timescale 1ns/1ps
module trap_status_unit #(
  parameter int NUM_IRQ    = 8,
  parameter int SLOT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_evt,
  input  logic               exc_req,
  input  logic [4:0]         exc_code,
  input  logic [31:0]        cur_pc,
  input  logic               cur_in_slot,
  input  logic [1:0]         cur_cop,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               eret,
  input  logic               sw_we,
  input  logic [1:0]         sw_sel,
  input  logic [31:0]        sw_wdata,
  input  logic [1:0]         rd_sel,
  output logic               trap_taken,
  output logic [4:0]         trap_code,
  output logic [31:0]        ret_target,
  output logic [31:0]        rd_data,
  output logic [31:0]        status_out
);
  import trap_pkg::*;

  logic [31:0]        status_r, cause_r, epc_r;
  logic [NUM_IRQ-1:0] ip_r;
  logic               do_erl, do_ret, do_wr;
  logic               wr_status, wr_cause, wr_epc;

  trap_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .st_ie    (status_r[ST_IE]),
    .st_exl   (status_r[ST_EXL]),
    .st_erl   (status_r[ST_ERL]),
    .st_im    (status_r[ST_IM +: NUM_IRQ]),
    .ip_q     (ip_r),
    .err_evt  (err_evt),
    .exc_req  (exc_req),
    .exc_code (exc_code),
    .eret     (eret),
    .sw_we    (sw_we),
    .trap_take(trap_taken),
    .trap_code(trap_code),
    .do_erl   (do_erl),
    .do_ret   (do_ret),
    .do_wr    (do_wr)
  );

  always_comb begin
    wr_status = do_wr & (regsel_e'(sw_sel) == SEL_STATUS);
    wr_cause  = do_wr & (regsel_e'(sw_sel) == SEL_CAUSE);
    wr_epc    = do_wr & (regsel_e'(sw_sel) == SEL_RETPC);
  end

  trap_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_erl  (do_erl),
    .do_trap (trap_taken),
    .do_ret  (do_ret),
    .wr_en   (wr_status),
    .wdata   (sw_wdata),
    .status_q(status_r)
  );

  trap_record #(.NUM_IRQ(NUM_IRQ), .SLOT_BYTES(SLOT_BYTES)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .do_trap    (trap_taken),
    .trap_code  (trap_code),
    .cur_pc     (cur_pc),
    .cur_in_slot(cur_in_slot),
    .cur_cop    (cur_cop),
    .wr_cause   (wr_cause),
    .wr_epc     (wr_epc),
    .wdata      (sw_wdata),
    .ip_q       (ip_r),
    .cause_q    (cause_r),
    .epc_q      (epc_r)
  );

  always_comb begin
    unique case (regsel_e'(rd_sel))
      SEL_STATUS: rd_data = status_r;
      SEL_CAUSE:  rd_data = cause_r;
      SEL_RETPC:  rd_data = epc_r;
      default:    rd_data = '0;
    endcase
  end

  assign ret_target = epc_r;
  assign status_out = status_r;
endmodule

// File: rtl/trap_status_unit_chk.sv
`timescale 1ns/1ps
module trap_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        err_evt,
  input logic        exc_req,
  input logic [4:0]  exc_code,
  input logic [31:0] cur_pc,
  input logic        cur_in_slot,
  input logic [1:0]  cur_cop,
  input logic        eret,
  input logic        trap_taken,
  input logic [4:0]  trap_code,
  input logic [31:0] status_r,
  input logic [31:0] cause_r,
  input logic [31:0] epc_r
);
  import trap_pkg::*;

  a_r2_level_raised: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> status_r[ST_EXL]);

  a_r2_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> cause_r[CA_CODE +: 5] == $past(trap_code));

  a_r7_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !err_evt) |-> (trap_taken && trap_code == exc_code));

  a_r6_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && (!status_r[ST_IE] || status_r[ST_EXL] || status_r[ST_ERL])) |-> !trap_taken);

  a_r3_slot_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && cur_in_slot) |=> (epc_r == $past(cur_pc) - 32'd4 && cause_r[CA_BD]));

  a_r3_plain_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && !cur_in_slot) |=> (epc_r == $past(cur_pc) && !cause_r[CA_BD]));

  a_r4_cop_field: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && trap_code == CODE_COPUNU) |=> cause_r[CA_CE +: 2] == $past(cur_cop));

  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !trap_taken);

  a_r9_err_level: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> status_r[ST_ERL]);

  a_r8_ret_order: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !err_evt && !trap_taken && status_r[ST_ERL]) |=> (!status_r[ST_ERL] && $stable(status_r[ST_EXL])));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_r & ~STAT_KEEP) == 32'd0) && ((cause_r & ~CAUSE_LIVE) == 32'd0));
endmodule

bind trap_status_unit trap_status_unit_chk u_chk (.*);

// File: tb/trap_status_unit_test.sv
`timescale 1ns/1ps
module trap_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        err_evt, exc_req, cur_in_slot, eret, sw_we;
  logic [4:0]  exc_code;
  logic [31:0] cur_pc, sw_wdata;
  logic [1:0]  cur_cop, sw_sel, rd_sel;
  logic [7:0]  irq_lines;
  logic        trap_taken;
  logic [4:0]  trap_code;
  logic [31:0] ret_target, rd_data, status_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  logic [31:0] m_st, m_epc;
  logic [4:0]  m_code;
  logic        m_bd;
  logic [1:0]  m_ce;
  logic [7:0]  m_ip;

  always #4 clk = ~clk;

  trap_status_unit uut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .exc_req(exc_req),
    .exc_code(exc_code), .cur_pc(cur_pc), .cur_in_slot(cur_in_slot),
    .cur_cop(cur_cop), .irq_lines(irq_lines), .eret(eret), .sw_we(sw_we),
    .sw_sel(sw_sel), .sw_wdata(sw_wdata), .rd_sel(rd_sel),
    .trap_taken(trap_taken), .trap_code(trap_code), .ret_target(ret_target),
    .rd_data(rd_data), .status_out(status_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_cause();
    return {m_bd, 1'b0, m_ce, 12'd0, m_ip, 1'b0, m_code, 2'b00};
  endfunction

  function automatic logic m_irq_ok();
    return m_st[0] & ~m_st[1] & ~m_st[2] & (|(m_ip & m_st[15:8]));
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return m_st;
      2'd1: return m_cause();
      2'd2: return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  task automatic idle();
    err_evt = 0; exc_req = 0; exc_code = 0; cur_pc = 32'h100; cur_in_slot = 0;
    cur_cop = 0; eret = 0; sw_we = 0; sw_sel = 0; sw_wdata = 0;
  endtask

  // called at a negedge with inputs set; checks, updates model, returns at next negedge
  task automatic step();
    logic take;
    logic [4:0] code;
    #1;
    take = ~err_evt & (exc_req | m_irq_ok());
    code = exc_req ? exc_code : 5'd0;
    chk({31'd0, trap_taken}, {31'd0, take}, exc_req ? "R2 R7 accept" : "R6 irq accept");
    if (take) chk({27'd0, trap_code}, {27'd0, code}, exc_req ? "R7 code" : "R6 code");
    chk(rd_data, m_read(rd_sel), "R10 read");
    chk(ret_target, m_epc, "R8 ret_target");
    if (err_evt) m_st[2] = 1'b1;
    else if (take) begin
      m_st[1] = 1'b1;
      m_code = code;
      m_bd = cur_in_slot;
      m_ce = (code == 5'd11) ? cur_cop : 2'd0;
      m_epc = cur_in_slot ? cur_pc - 32'd4 : cur_pc;
    end else if (eret) begin
      if (m_st[2]) m_st[2] = 1'b0; else m_st[1] = 1'b0;
    end else if (sw_we) begin
      case (sw_sel)
        2'd0: m_st = sw_wdata & 32'hF040_FF1F;
        2'd1: begin m_code = sw_wdata[6:2]; m_bd = sw_wdata[31]; m_ce = sw_wdata[29:28]; end
        2'd2: m_epc = sw_wdata;
        default: ;
      endcase
    end
    m_ip = irq_lines;
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] s, input logic [31:0] exp, input string tag);
    rd_sel = s;
    #1;
    chk(rd_data, exp, tag);
  endtask

  task automatic sw_write(input logic [1:0] s, input logic [31:0] d);
    idle(); sw_we = 1; sw_sel = s; sw_wdata = d;
    step();
    idle();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    rst_n = 0; idle(); irq_lines = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_st = 32'h0040_0004; m_epc = 0; m_code = 0; m_bd = 0; m_ce = 0; m_ip = 0;

    // R1 reset values
    peek(2'd0, 32'h0040_0004, "R1 status");
    peek(2'd1, 32'h0, "R1 cause");
    peek(2'd2, 32'h0, "R1 retpc");
    peek(2'd3, 32'h0, "R10 none");

    // R11 writable masks
    sw_write(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, 32'hF040_FF1F, "R11 status mask");
    sw_write(2'd1, 32'hFFFF_FFFF);
    peek(2'd1, 32'hB000_007C, "R11 cause mask");

    // R5 pending lines lag one cycle, not writable
    irq_lines = 8'hA5;
    sw_write(2'd1, 32'h0000_FF00);
    peek(2'd1, 32'h0000_A500, "R5 ip");
    irq_lines = 8'h00;

    // R9 error event blocks write in same cycle
    idle(); err_evt = 1; sw_we = 1; sw_sel = 0; sw_wdata = 32'h0;
    step(); idle();
    peek(2'd0, 32'hF040_FF1F, "R9 erl set, write dropped");

    // R8 return clears error level first, then exception level
    idle(); eret = 1; step(); idle();
    peek(2'd0, 32'hF040_FF1B, "R8 erl first");
    idle(); eret = 1; step(); idle();
    peek(2'd0, 32'hF040_FF19, "R8 exl second");

    // R3 slot correction and R4 coprocessor field
    idle(); exc_req = 1; exc_code = 5'd11; cur_pc = 32'h0000_1000;
    cur_in_slot = 1; cur_cop = 2'd2;
    step(); idle();
    peek(2'd2, 32'h0000_0FFC, "R3 slot retpc");
    peek(2'd1, 32'hA000_002C, "R4 cop and R3 bd");
    chk(ret_target, 32'h0000_0FFC, "R8 target");

    // R6 interrupt: enable, clear levels, mask line 3
    sw_write(2'd0, 32'h0000_0801);
    irq_lines = 8'h08; idle(); step();
    idle(); cur_pc = 32'h2000; step();
    peek(2'd1, 32'h0000_0800, "R6 code 0");
    peek(2'd2, 32'h0000_2000, "R3 plain retpc");

    // R7 both at once
    sw_write(2'd0, 32'h0000_0801);
    idle(); exc_req = 1; exc_code = 5'd8; step(); idle();
    peek(2'd1, 32'h0000_0820, "R7 sync wins");
    irq_lines = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] codes [15];
      codes = '{5'd0,5'd1,5'd2,5'd3,5'd4,5'd5,5'd6,5'd7,5'd8,5'd9,5'd10,5'd11,5'd12,5'd13,5'd23};
      err_evt     = ($urandom % 40) == 0;
      exc_req     = ($urandom % 6) == 0;
      exc_code    = codes[$urandom % 15];
      cur_pc      = $urandom & 32'hFFFF_FFFC;
      cur_in_slot = $urandom % 2;
      cur_cop     = $urandom % 4;
      irq_lines   = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      eret        = ($urandom % 8) == 0;
      sw_we       = ($urandom % 3) == 0;
      sw_sel      = $urandom % 4;
      sw_wdata    = $urandom;
      if (sw_sel == 2'd0 && ($urandom % 2)) sw_wdata[2:1] = 2'b00;
      rd_sel      = $urandom % 4;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule